// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block is the per-channel software flow control core of a serial port. On the transmit side it watches the receive FIFO fill level. When the local receiver is close to full, it asks the transmitter to insert a pause character. Once the receiver has drained, it asks for a resume character. On the receive side it compares every character that arrives against four programmed control characters. It keeps a paused/running state that gates how the transmitter drains its own FIFO.

Both sides are programmed with a 2-bit mode field. Set 1 uses the first resume/pause pair as single characters. Set 2 uses the second pair as single characters. Pair mode uses two-character sequences: first character of set 1, then character of set 2. An optional "any character resumes" input lets traffic of any kind restart a paused link. The serial shifters, the FIFOs and the baud logic are outside this block. The block only raises insertion requests, which the transmitter acknowledges one character at a time, and it reports whether FIFO data may be sent.

Top module: `swfc_engine`

## Requirements
- R1: `tx_mode` = 00 disables the transmit side. One cycle after it is seen, both insertion requests are low and `xoff_sent` is 0. Any nonzero value enables it. The inserted character follows the mode: 01 sends `xon_a`/`xoff_a`, 10 sends `xon_b`/`xoff_b`, and 11 sends the `_a` character followed by the `_b` character.
- R2: With the transmit side enabled, no request pending and no pause already sent, a `fill_level` strictly above `hi_mark` raises `ins_xoff_req` on the next cycle and sets `xoff_sent`. A level equal to `hi_mark` does not.
- R3: Enabling the transmit side never produces a resume request by itself. `ins_xon_req` rises only after a pause was sent and `fill_level` has fallen to `lo_mark` or below. The same cycle clears `xoff_sent`.
- R4: A raised request, together with its `ins_char`, holds until `ins_ack` is high at a clock edge. At most one of the two requests is high at a time.
- R5: In pair mode (11) the first acknowledge moves `ins_char` from the `_a` to the `_b` character with the request still high. The second acknowledge drops the request.
- R6: `rx_mode` = 00 holds `tx_allow` at 1 and clears any partial sequence on the next cycle. Reset leaves `tx_allow` = 1, no requests, `xoff_sent` = 0 and `seq_pending` = 0.
- R7: In `rx_mode` 01 or 10, a received character equal to that set's pause character drives `tx_allow` to 0 on the next cycle. A character equal to that set's resume character drives it to 1. Characters of the other set have no effect.
- R8: In pair mode, resume-first, resume-first, resume-second gives `tx_allow` = 1, and pause-first, pause-first, pause-second gives `tx_allow` = 0. A repeated first character restarts the sequence rather than breaking it. `seq_pending` is 1 while a first character waits.
- R9: In pair mode, any character that neither completes nor starts a sequence clears the partial match, so a later second character alone changes nothing.
- R10: When a set's resume and pause characters are equal, a match counts as resume.
- R11: With `xon_any` = 1 and receive control enabled, every received character that does not complete a pause returns `tx_allow` to 1.
- R12: Without `rx_valid`, `tx_allow` and `seq_pending` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 2 | Transmit-side control mode (00 off, 01 set a, 10 set b, 11 pair) |
| rx_mode | input | 2 | Receive-side control mode (same encoding) |
| xon_any | input | 1 | Any received character resumes transmission |
| xon_a | input | CHAR_W | Resume character, set a |
| xon_b | input | CHAR_W | Resume character, set b |
| xoff_a | input | CHAR_W | Pause character, set a |
| xoff_b | input | CHAR_W | Pause character, set b |
| rx_valid | input | 1 | Strobe: a received character is on `rx_data` |
| rx_data | input | CHAR_W | Received character |
| fill_level | input | CNT_W | Receive FIFO occupancy |
| hi_mark | input | CNT_W | Occupancy above which a pause is requested |
| lo_mark | input | CNT_W | Occupancy at or below which a resume is requested |
| ins_ack | input | 1 | Transmitter has taken the offered control character |
| ins_xon_req | output | 1 | Request to insert a resume character |
| ins_xoff_req | output | 1 | Request to insert a pause character |
| ins_char | output | CHAR_W | Character to insert while a request is high, else 0 |
| tx_allow | output | 1 | FIFO data may be transmitted |
| xoff_sent | output | 1 | A pause has been requested and not yet followed by a resume |
| seq_pending | output | 1 | A first character of a pair sequence is waiting |

## Verification
The checker assumes that `ins_ack` matters only while a request is high and that the control characters stay fixed while a request is held, so `ins_char` stability is judged only with the mode unchanged. It also assumes that `lo_mark` is below `hi_mark`, so that a pause and a resume cannot both be due at once. The stimulus keeps the marks fixed at 10 and 4 with fill levels between 0 and 20. It changes the control characters only in a directed segment with no request pending, and it draws received characters mostly from the four programmed values so that the sequence logic is exercised often.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    // Mode field shared by the transmit and receive sides
    typedef enum logic [1:0] {
        FC_OFF  = 2'b00,
        FC_SETA = 2'b01,
        FC_SETB = 2'b10,
        FC_PAIR = 2'b11
    } fc_mode_e;

    // Pending insertion request
    typedef enum logic [1:0] {
        INS_NONE = 2'b00,
        INS_XON  = 2'b01,
        INS_XOFF = 2'b10
    } ins_kind_e;

    // Selects the a or b character of a set for the given mode and pair position
    function automatic logic pick_b(fc_mode_e m, logic second);
        return (m == FC_SETB) || ((m == FC_PAIR) && second);
    endfunction

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  fc_mode_e          mode,
    input  logic              any_resumes,
    input  logic [CHAR_W-1:0] on_a,
    input  logic [CHAR_W-1:0] on_b,
    input  logic [CHAR_W-1:0] off_a,
    input  logic [CHAR_W-1:0] off_b,
    input  logic              valid,
    input  logic [CHAR_W-1:0] data,
    output logic              paused,
    output logic              partial
);

    logic seen_on;
    logic seen_off;

    // Single-character comparison set
    logic [CHAR_W-1:0] sel_on;
    logic [CHAR_W-1:0] sel_off;
    always_comb begin
        sel_on  = pick_b(mode, 1'b0) ? on_b  : on_a;
        sel_off = pick_b(mode, 1'b0) ? off_b : off_a;
    end

    logic hit_on;
    logic hit_off;
    logic done_on;
    logic done_off;
    logic first_on;
    logic first_off;
    always_comb begin
        hit_on    = (data == sel_on);
        hit_off   = (data == sel_off) && !hit_on;
        done_on   = seen_on && (data == on_b);
        done_off  = seen_off && (data == off_b) && !done_on;
        first_on  = (data == on_a);
        first_off = (data == off_a) && !first_on;
    end

    always_ff @(posedge clk) begin
        if (rst || mode == FC_OFF) begin
            paused   <= 1'b0;
            seen_on  <= 1'b0;
            seen_off <= 1'b0;
        end else if (valid) begin
            if (mode != FC_PAIR) begin
                seen_on  <= 1'b0;
                seen_off <= 1'b0;
                if (hit_on)
                    paused <= 1'b0;
                else if (hit_off)
                    paused <= 1'b1;
                else if (any_resumes)
                    paused <= 1'b0;
            end else begin
                if (done_on) begin
                    paused   <= 1'b0;
                    seen_on  <= 1'b0;
                    seen_off <= 1'b0;
                end else if (done_off) begin
                    paused   <= 1'b1;
                    seen_on  <= 1'b0;
                    seen_off <= 1'b0;
                end else begin
                    seen_on  <= first_on;
                    seen_off <= first_off;
                    if (any_resumes)
                        paused <= 1'b0;
                end
            end
        end
    end

    assign partial = seen_on | seen_off;

endmodule

// File: rtl/swfc_tx_req.sv
module swfc_tx_req
    import swfc_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  fc_mode_e         mode,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    input  logic             ack,
    output ins_kind_e        kind,
    output logic             second,
    output logic             sent
);

    logic want_off;
    logic want_on;
    always_comb begin
        want_off = !sent && (fill > hi);
        want_on  = sent && (fill <= lo);
    end

    always_ff @(posedge clk) begin
        if (rst || mode == FC_OFF) begin
            kind   <= INS_NONE;
            second <= 1'b0;
            sent   <= 1'b0;
        end else if (kind != INS_NONE) begin
            if (ack) begin
                if (mode == FC_PAIR && !second) begin
                    second <= 1'b1;
                end else begin
                    second <= 1'b0;
                    kind   <= INS_NONE;
                end
            end
        end else if (want_off) begin
            kind <= INS_XOFF;
            sent <= 1'b1;
        end else if (want_on) begin
            kind <= INS_XON;
            sent <= 1'b0;
        end
    end

endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        tx_mode,
    input  logic [1:0]        rx_mode,
    input  logic              xon_any,
    input  logic [CHAR_W-1:0] xon_a,
    input  logic [CHAR_W-1:0] xon_b,
    input  logic [CHAR_W-1:0] xoff_a,
    input  logic [CHAR_W-1:0] xoff_b,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CNT_W-1:0]  fill_level,
    input  logic [CNT_W-1:0]  hi_mark,
    input  logic [CNT_W-1:0]  lo_mark,
    input  logic              ins_ack,
    output logic              ins_xon_req,
    output logic              ins_xoff_req,
    output logic [CHAR_W-1:0] ins_char,
    output logic              tx_allow,
    output logic              xoff_sent,
    output logic              seq_pending
);

    fc_mode_e  txm;
    fc_mode_e  rxm;
    ins_kind_e kind;
    logic      second;
    logic      paused;

    assign txm = fc_mode_e'(tx_mode);
    assign rxm = fc_mode_e'(rx_mode);

    swfc_tx_req #(.CNT_W(CNT_W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .mode   (txm),
        .fill   (fill_level),
        .hi     (hi_mark),
        .lo     (lo_mark),
        .ack    (ins_ack),
        .kind   (kind),
        .second (second),
        .sent   (xoff_sent)
    );

    swfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .mode        (rxm),
        .any_resumes (xon_any),
        .on_a        (xon_a),
        .on_b        (xon_b),
        .off_a       (xoff_a),
        .off_b       (xoff_b),
        .valid       (rx_valid),
        .data        (rx_data),
        .paused      (paused),
        .partial     (seq_pending)
    );

    always_comb begin
        ins_xon_req  = (kind == INS_XON);
        ins_xoff_req = (kind == INS_XOFF);
        unique case (kind)
            INS_XON:  ins_char = pick_b(txm, second) ? xon_b : xon_a;
            INS_XOFF: ins_char = pick_b(txm, second) ? xoff_b : xoff_a;
            default:  ins_char = '0;
        endcase
        tx_allow = !paused;
    end

endmodule

// File: rtl/swfc_chk.sv
module swfc_chk #(
    parameter int CHAR_W = 8,
    parameter int CNT_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        tx_mode,
    input logic [1:0]        rx_mode,
    input logic [CHAR_W-1:0] xon_a,
    input logic [CHAR_W-1:0] xoff_a,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic [CNT_W-1:0]  fill_level,
    input logic [CNT_W-1:0]  hi_mark,
    input logic              ins_ack,
    input logic              ins_xon_req,
    input logic              ins_xoff_req,
    input logic [CHAR_W-1:0] ins_char,
    input logic              tx_allow,
    input logic              xoff_sent,
    input logic              seq_pending
);

    // R1
    tx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_mode == 2'b00) |=> (!ins_xon_req && !ins_xoff_req && !xoff_sent));

    // R2
    xoff_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_mode != 2'b00 && !xoff_sent && !ins_xon_req && !ins_xoff_req
         && fill_level > hi_mark) |=> ins_xoff_req);

    // R4
    hold_xoff_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_xoff_req && !ins_ack && tx_mode != 2'b00) |=> ins_xoff_req);

    // R4
    hold_xon_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_xon_req && !ins_ack && tx_mode != 2'b00) |=> ins_xon_req);

    // R4
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(ins_xon_req && ins_xoff_req));

    // R6
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == 2'b00) |=> (tx_allow && !seq_pending));

    // R7
    single_xoff_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_mode == 2'b01 && rx_data == xoff_a && rx_data != xon_a)
        |=> !tx_allow);

    // R10
    single_xon_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_mode == 2'b01 && rx_data == xon_a) |=> tx_allow);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && rx_mode != 2'b00) |=> ($stable(tx_allow) && $stable(seq_pending)));

endmodule

bind swfc_engine swfc_chk #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_mode      (tx_mode),
    .rx_mode      (rx_mode),
    .xon_a        (xon_a),
    .xoff_a       (xoff_a),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .fill_level   (fill_level),
    .hi_mark      (hi_mark),
    .ins_ack      (ins_ack),
    .ins_xon_req  (ins_xon_req),
    .ins_xoff_req (ins_xoff_req),
    .ins_char     (ins_char),
    .tx_allow     (tx_allow),
    .xoff_sent    (xoff_sent),
    .seq_pending  (seq_pending)
);

// File: tb/sim_swfc_engine.sv
module sim_swfc_engine;

    localparam int CW = 8;
    localparam int NW = 9;
    localparam logic [CW-1:0] ON_A  = 8'hA1;
    localparam logic [CW-1:0] ON_B  = 8'hA2;
    localparam logic [CW-1:0] OFF_A = 8'hB1;
    localparam logic [CW-1:0] OFF_B = 8'hB2;
    localparam logic [CW-1:0] OTHER = 8'h55;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic [1:0]    tx_mode;
    logic [1:0]    rx_mode;
    logic          xon_any;
    logic [CW-1:0] xon_a, xon_b, xoff_a, xoff_b;
    logic          rx_valid;
    logic [CW-1:0] rx_data;
    logic [NW-1:0] fill_level, hi_mark, lo_mark;
    logic          ins_ack;
    logic          ins_xon_req, ins_xoff_req;
    logic [CW-1:0] ins_char;
    logic          tx_allow, xoff_sent, seq_pending;

    swfc_engine #(.CHAR_W(CW), .CNT_W(NW)) u0 (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .xon_any(xon_any), .xon_a(xon_a), .xon_b(xon_b),
        .xoff_a(xoff_a), .xoff_b(xoff_b), .rx_valid(rx_valid),
        .rx_data(rx_data), .fill_level(fill_level), .hi_mark(hi_mark),
        .lo_mark(lo_mark), .ins_ack(ins_ack), .ins_xon_req(ins_xon_req),
        .ins_xoff_req(ins_xoff_req), .ins_char(ins_char),
        .tx_allow(tx_allow), .xoff_sent(xoff_sent), .seq_pending(seq_pending)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state, advanced from the requirements at each edge
    logic m_paused, m_son, m_soff;
    int   m_kind;      // 0 none, 1 resume, 2 pause
    logic m_second, m_sent;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic use_b(input logic [1:0] m, input logic sec);
        return (m == 2'b10) || (m == 2'b11 && sec);
    endfunction

    task automatic model_step();
        // transmit side
        if (rst || tx_mode == 2'b00) begin
            m_kind = 0; m_second = 0; m_sent = 0;
        end else if (m_kind != 0) begin
            if (ins_ack) begin
                if (tx_mode == 2'b11 && !m_second) m_second = 1;
                else begin m_second = 0; m_kind = 0; end
            end
        end else if (!m_sent && fill_level > hi_mark) begin
            m_kind = 2; m_sent = 1;
        end else if (m_sent && fill_level <= lo_mark) begin
            m_kind = 1; m_sent = 0;
        end
        // receive side
        if (rst || rx_mode == 2'b00) begin
            m_paused = 0; m_son = 0; m_soff = 0;
        end else if (rx_valid) begin
            if (rx_mode != 2'b11) begin
                logic [CW-1:0] on_c, off_c;
                on_c  = (rx_mode == 2'b10) ? xon_b : xon_a;
                off_c = (rx_mode == 2'b10) ? xoff_b : xoff_a;
                m_son = 0; m_soff = 0;
                if (rx_data == on_c) m_paused = 0;
                else if (rx_data == off_c) m_paused = 1;
                else if (xon_any) m_paused = 0;
            end else if (m_son && rx_data == xon_b) begin
                m_paused = 0; m_son = 0; m_soff = 0;
            end else if (m_soff && rx_data == xoff_b) begin
                m_paused = 1; m_son = 0; m_soff = 0;
            end else begin
                m_son  = (rx_data == xon_a);
                m_soff = (rx_data == xoff_a) && (rx_data != xon_a);
                if (xon_any) m_paused = 0;
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_char(input logic [CW-1:0] c);
        rx_valid = 1; rx_data = c;
        tick();
        rx_valid = 0;
    endtask

    task automatic model_check(input string tag);
        logic [CW-1:0] exp_c;
        exp_c = '0;
        if (m_kind == 1) exp_c = use_b(tx_mode, m_second) ? xon_b : xon_a;
        if (m_kind == 2) exp_c = use_b(tx_mode, m_second) ? xoff_b : xoff_a;
        chk(tag, {31'd0, tx_allow}, {31'd0, !m_paused});
        chk(tag, {31'd0, seq_pending}, {31'd0, m_son | m_soff});
        chk(tag, {31'd0, ins_xon_req}, {31'd0, m_kind == 1});
        chk(tag, {31'd0, ins_xoff_req}, {31'd0, m_kind == 2});
        chk(tag, {24'd0, ins_char}, {24'd0, exp_c});
        chk(tag, {31'd0, xoff_sent}, {31'd0, m_sent});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; tx_mode = 0; rx_mode = 0; xon_any = 0;
        xon_a = ON_A; xon_b = ON_B; xoff_a = OFF_A; xoff_b = OFF_B;
        rx_valid = 0; rx_data = 0; fill_level = 0; hi_mark = 10; lo_mark = 4;
        ins_ack = 0;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        // R6 reset state
        chk("R6 reset tx_allow", {31'd0, tx_allow}, 1);
        chk("R6 reset requests", {30'd0, ins_xon_req, ins_xoff_req}, 0);
        chk("R6 reset xoff_sent", {31'd0, xoff_sent}, 0);

        // R3: enabling sends nothing
        tx_mode = 2'b01; tick(); tick();
        chk("R3 no resume at enable", {30'd0, ins_xon_req, ins_xoff_req}, 0);
        // R2: boundary at hi_mark
        fill_level = 10; tick();
        chk("R2 equal to mark no pause", {31'd0, ins_xoff_req}, 0);
        fill_level = 11; tick();
        chk("R2 pause raised", {31'd0, ins_xoff_req}, 1);
        chk("R1 set a pause char", {24'd0, ins_char}, {24'd0, OFF_A});
        chk("R2 xoff_sent", {31'd0, xoff_sent}, 1);
        tick(); tick();
        chk("R4 held without ack", {31'd0, ins_xoff_req}, 1);
        ins_ack = 1; tick(); ins_ack = 0;
        chk("R4 cleared by ack", {31'd0, ins_xoff_req}, 0);
        tick();
        chk("R2 no repeat pause", {31'd0, ins_xoff_req}, 0);
        fill_level = 5; tick();
        chk("R3 above low mark no resume", {31'd0, ins_xon_req}, 0);
        fill_level = 4; tick();
        chk("R3 resume at low mark", {31'd0, ins_xon_req}, 1);
        chk("R3 resume char", {24'd0, ins_char}, {24'd0, ON_A});
        chk("R3 xoff_sent cleared", {31'd0, xoff_sent}, 0);
        ins_ack = 1; tick(); ins_ack = 0;

        // R5: pair mode
        tx_mode = 2'b11; fill_level = 11; tick();
        chk("R5 first pause char", {24'd0, ins_char}, {24'd0, OFF_A});
        ins_ack = 1; tick();
        chk("R5 still requesting", {31'd0, ins_xoff_req}, 1);
        chk("R5 second pause char", {24'd0, ins_char}, {24'd0, OFF_B});
        tick(); ins_ack = 0;
        chk("R5 done after two acks", {31'd0, ins_xoff_req}, 0);

        // R1: set b characters, then disable with a request pending
        tx_mode = 2'b10; fill_level = 3; tick();
        chk("R1 set b resume char", {24'd0, ins_char}, {24'd0, ON_B});
        ins_ack = 1; tick(); ins_ack = 0;
        fill_level = 11; tick();
        chk("R1 set b pause char", {24'd0, ins_char}, {24'd0, OFF_B});
        tx_mode = 2'b00; tick();
        chk("R1 disabled clears request", {31'd0, ins_xoff_req}, 0);
        chk("R1 disabled clears sent", {31'd0, xoff_sent}, 0);
        tx_mode = 2'b01; fill_level = 0; tick(); tick();
        chk("R3 re-enable no resume", {31'd0, ins_xon_req}, 0);

        // R7 single-character matching
        rx_mode = 2'b01;
        rx_char(OFF_A);
        chk("R7 pause set a", {31'd0, tx_allow}, 0);
        tick(); tick();
        chk("R12 idle keeps pause", {31'd0, tx_allow}, 0);
        rx_char(ON_B);
        chk("R7 other set ignored", {31'd0, tx_allow}, 0);
        rx_char(ON_A);
        chk("R7 resume set a", {31'd0, tx_allow}, 1);
        rx_mode = 2'b10;
        rx_char(OFF_A);
        chk("R7 set a ignored in set b", {31'd0, tx_allow}, 1);
        rx_char(OFF_B);
        chk("R7 pause set b", {31'd0, tx_allow}, 0);
        rx_char(ON_B);
        chk("R7 resume set b", {31'd0, tx_allow}, 1);

        // R8 two-character sequences
        rx_mode = 2'b11;
        rx_char(OFF_A);
        chk("R8 partial flagged", {31'd0, seq_pending}, 1);
        rx_char(OFF_A);
        chk("R8 repeat first still running", {31'd0, tx_allow}, 1);
        rx_char(OFF_B);
        chk("R8 pause sequence", {31'd0, tx_allow}, 0);
        chk("R8 partial done", {31'd0, seq_pending}, 0);
        rx_char(ON_A); rx_char(ON_A); rx_char(ON_B);
        chk("R8 resume sequence", {31'd0, tx_allow}, 1);

        // R9 broken sequence
        rx_char(OFF_A); rx_char(OTHER);
        chk("R9 partial cleared", {31'd0, seq_pending}, 0);
        rx_char(OFF_B);
        chk("R9 lone second ignored", {31'd0, tx_allow}, 1);
        rx_char(OFF_A); rx_char(OFF_B);
        rx_char(ON_A); rx_char(OTHER); rx_char(ON_B);
        chk("R9 broken resume ignored", {31'd0, tx_allow}, 0);

        // R10 identical characters
        rx_mode = 2'b01;
        rx_char(OFF_A);
        xoff_a = ON_A;
        rx_char(ON_A);
        chk("R10 identical counts as resume", {31'd0, tx_allow}, 1);
        rx_char(ON_A);
        chk("R10 identical never pauses", {31'd0, tx_allow}, 1);
        xoff_a = OFF_A;

        // R11 any character resumes
        rx_char(OFF_A);
        xon_any = 1;
        rx_char(OTHER);
        chk("R11 any char resumes", {31'd0, tx_allow}, 1);
        rx_char(OFF_A);
        chk("R11 pause still honoured", {31'd0, tx_allow}, 0);
        xon_any = 0;

        // R6 receive side off
        rx_mode = 2'b00; tick();
        chk("R6 off forces allow", {31'd0, tx_allow}, 1);

        // Random phase against the reference state
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                rx_mode = 2'($urandom % 4);
                tx_mode = 2'($urandom % 4);
                xon_any = ($urandom % 4) == 0;
            end
            fill_level = NW'($urandom % 21);
            ins_ack = $urandom % 2;
            rx_valid = ($urandom % 3) != 0;
            case ($urandom % 6)
                0: rx_data = ON_A;
                1: rx_data = ON_B;
                2: rx_data = OFF_A;
                3: rx_data = OFF_B;
                default: rx_data = 8'($urandom);
            endcase
            tick();
            model_check("R7 R8 R9 R11 R2 R3 R4 R5 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule